// File: doc/BRIEF.md
# Ethernet Transmit Fault Monitor

This block sits beside the transmit engine of a half-duplex Ethernet channel and watches for two faults: a collision that arrives too far into a frame (a late collision), and a transceiver that fails to signal its signal-quality self-test (a missing heartbeat). The engine tells the monitor when it is transmitting, strobes once per byte sent, and strobes once at the end of each frame. The transceiver's collision line is the other input.

A late collision makes the monitor request an abort of the current buffer and close it with a late-collision status bit. The channel is then held halted (`tx_permit` low) until software issues a restart command. A collision seen before the late threshold is passed on as an ordinary collision for the backoff logic. With heartbeat checking on, the end of each frame opens a fixed window of clock cycles. A collision inside that window is taken as a healthy heartbeat, and the buffer closes clean. If the window runs out with no collision, the buffer closes with a heartbeat-error bit. Either fault sets a sticky event flag that raises the interrupt line when the interrupt is enabled.

Top module: `txmon_top`

## Requirements
- R1: After reset, `tx_permit` is 1 and `abort_req`, `norm_col`, `close_vld`, `close_late_col`, `close_hb_err`, `evt_flag` and `irq` are all 0.
- R2: A running channel may sample `col_in` high while `tx_active` is high after at least `LATE_BYTES` (default 64) `tx_byte` strobes have been counted since `tx_active` rose. In the next cycle `abort_req` is high for exactly one cycle, `close_vld` and `close_late_col` are 1, and `close_hb_err` is 0.
- R3: A collision sampled while `tx_active` is high after fewer than `LATE_BYTES` byte strobes gives a one-cycle `norm_col` pulse in the next cycle. It gives no abort, no close and no event.
- R4: After a late collision, `tx_permit` is 0. Collisions and frame-end strobes then produce no `abort_req`, `norm_col` or `close_vld` until `restart_cmd` is sampled. `tx_permit` is 1 in the cycle after that.
- R5: With `hb_check_en` = 1, a frame-end strobe opens a window covering the next `HB_WINDOW` (default 20) clock edges. A collision sampled at any of those edges closes the buffer in the following cycle with both status bits 0, and it sets no event.
- R6: With `hb_check_en` = 1 and no collision in the window, the buffer closes with `close_hb_err` = 1 in the cycle after the last window edge, and `evt_flag` becomes 1. A collision after the window has no effect.
- R7: With `hb_check_en` = 0, a frame-end strobe closes the buffer in the next cycle with both status bits 0. No window is opened and no heartbeat error follows.
- R8: `evt_flag` stays set until a cycle with `evt_clr` high clears it. If a new fault and `evt_clr` fall in the same cycle, the fault wins.
- R9: `irq` is 1 exactly when `evt_flag` is 1 and `irq_en` is 1.
- R10: `close_vld` is a one-cycle strobe, and `close_late_col` and `close_hb_err` are 0 whenever `close_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_active | input | 1 | Transmit engine is sending a frame |
| tx_byte | input | 1 | One strobe per byte sent |
| tx_end | input | 1 | One-cycle end-of-frame strobe |
| col_in | input | 1 | Collision indication from transceiver |
| hb_check_en | input | 1 | Enable heartbeat checking |
| irq_en | input | 1 | Enable the transmit-error interrupt |
| restart_cmd | input | 1 | Restart-transmit command pulse |
| evt_clr | input | 1 | Write-one-to-clear pulse for the event flag |
| tx_permit | output | 1 | Channel may transmit (0 while halted) |
| abort_req | output | 1 | Request to stop sending the current buffer |
| norm_col | output | 1 | Ordinary (early) collision pulse |
| close_vld | output | 1 | Buffer-close strobe |
| close_late_col | output | 1 | Late-collision status bit of the closed buffer |
| close_hb_err | output | 1 | Heartbeat-error status bit of the closed buffer |
| evt_flag | output | 1 | Sticky transmit-error event |
| irq | output | 1 | Transmit-error interrupt |

## Verification
The hardest cases to reach are the edges of the two thresholds. One is a collision on exactly the `LATE_BYTES`-th byte compared with one byte earlier. The other is a heartbeat on the last cycle of the window compared with one cycle later. Both need the stimulus placed to the exact clock. The bench sweeps the collision position over every byte count from 0 to a few past the limit. It also sweeps the heartbeat over every cycle offset from 1 to one past the window, with the interrupt enabled and disabled. At each cycle it checks that no close strobe comes early.

// File: rtl/txmon_pkg.sv
package txmon_pkg;

    typedef enum logic {
        CH_RUN  = 1'b0,
        CH_HALT = 1'b1
    } chan_state_e;

    typedef enum logic [1:0] {
        HB_NONE = 2'd0,
        HB_GOOD = 2'd1,
        HB_MISS = 2'd2
    } hb_verdict_e;

    typedef struct packed {
        logic late_col;
        logic hb_err;
    } close_stat_t;

    function automatic int cnt_width(input int maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/txmon_byte_cnt.sv
module txmon_byte_cnt #(
    parameter int LATE_BYTES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic byte_stb,
    output logic late_zone
);
    localparam int CW = txmon_pkg::cnt_width(LATE_BYTES);
    localparam logic [CW-1:0] LIMIT = CW'(LATE_BYTES);

    logic [CW-1:0] cnt;

    // Saturating count of bytes since the frame began
    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (byte_stb && (cnt != LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign late_zone = (cnt == LIMIT);
endmodule

// File: rtl/txmon_hb_window.sv
module txmon_hb_window
    import txmon_pkg::*;
#(
    parameter int HB_WINDOW = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        arm,
    input  logic        cancel,
    input  logic        col_in,
    output hb_verdict_e verdict
);
    localparam int WW = cnt_width(HB_WINDOW);
    localparam logic [WW-1:0] WLEN = WW'(HB_WINDOW);
    localparam logic [WW-1:0] WONE = WW'(1);

    logic          armed;
    logic [WW-1:0] wcnt;

    // A collision wins over expiry on the last window edge
    always_comb begin
        verdict = HB_NONE;
        if (armed && col_in) begin
            verdict = HB_GOOD;
        end else if (armed && (wcnt == WONE)) begin
            verdict = HB_MISS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            armed <= 1'b0;
            wcnt  <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            wcnt  <= WLEN;
        end else if (verdict != HB_NONE) begin
            armed <= 1'b0;
            wcnt  <= '0;
        end else if (armed) begin
            wcnt  <= wcnt - 1'b1;
        end
    end
endmodule

// File: rtl/txmon_evt_flag.sv
module txmon_evt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Setting has priority over the write-one-to-clear pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/txmon_top.sv
module txmon_top
    import txmon_pkg::*;
#(
    parameter int LATE_BYTES = 64,
    parameter int HB_WINDOW  = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_active,
    input  logic tx_byte,
    input  logic tx_end,
    input  logic col_in,
    input  logic hb_check_en,
    input  logic irq_en,
    input  logic restart_cmd,
    input  logic evt_clr,
    output logic tx_permit,
    output logic abort_req,
    output logic norm_col,
    output logic close_vld,
    output logic close_late_col,
    output logic close_hb_err,
    output logic evt_flag,
    output logic irq
);
    chan_state_e state_q;
    logic        running;
    logic        late_zone;
    logic        late_hit;
    logic        norm_hit;
    logic        hb_arm;
    logic        plain_close;
    hb_verdict_e verdict;
    logic        close_d;
    close_stat_t stat_d;
    close_stat_t stat_q;
    logic        evt_set;

    assign running = (state_q == CH_RUN);

    txmon_byte_cnt #(.LATE_BYTES(LATE_BYTES)) u_bytes (
        .clk      (clk),
        .rst      (rst),
        .active   (tx_active && running),
        .byte_stb (tx_byte),
        .late_zone(late_zone)
    );

    assign late_hit    = running && tx_active && col_in && late_zone;
    assign norm_hit    = running && tx_active && col_in && !late_zone;
    assign hb_arm      = running && tx_end && hb_check_en && !late_hit;
    assign plain_close = running && tx_end && !hb_check_en && !late_hit;

    txmon_hb_window #(.HB_WINDOW(HB_WINDOW)) u_hbwin (
        .clk    (clk),
        .rst    (rst),
        .arm    (hb_arm),
        .cancel (late_hit),
        .col_in (col_in),
        .verdict(verdict)
    );

    // Close request: late collision > heartbeat verdict > plain frame end
    always_comb begin
        close_d = 1'b0;
        stat_d  = '0;
        if (late_hit) begin
            close_d         = 1'b1;
            stat_d.late_col = 1'b1;
        end else if (verdict != HB_NONE) begin
            close_d       = 1'b1;
            stat_d.hb_err = (verdict == HB_MISS);
        end else if (plain_close) begin
            close_d = 1'b1;
        end
    end

    assign evt_set = late_hit || ((verdict == HB_MISS) && !late_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= CH_RUN;
            abort_req <= 1'b0;
            norm_col  <= 1'b0;
            close_vld <= 1'b0;
            stat_q    <= '0;
        end else begin
            abort_req <= late_hit;
            norm_col  <= norm_hit;
            close_vld <= close_d;
            stat_q    <= stat_d;
            case (state_q)
                CH_RUN:  if (late_hit)    state_q <= CH_HALT;
                CH_HALT: if (restart_cmd) state_q <= CH_RUN;
                default: state_q <= CH_RUN;
            endcase
        end
    end

    txmon_evt_flag u_evt (
        .clk (clk),
        .rst (rst),
        .set (evt_set),
        .clr (evt_clr),
        .flag(evt_flag)
    );

    assign tx_permit      = running;
    assign close_late_col = stat_q.late_col;
    assign close_hb_err   = stat_q.hb_err;
    assign irq            = evt_flag && irq_en;
endmodule

// File: rtl/txmon_checker.sv
module txmon_checker (
    input logic clk,
    input logic rst,
    input logic restart_cmd,
    input logic evt_clr,
    input logic tx_permit,
    input logic abort_req,
    input logic norm_col,
    input logic close_vld,
    input logic close_late_col,
    input logic close_hb_err,
    input logic evt_flag
);
    // R2: abort lasts one cycle
    p_abort_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        abort_req |=> !abort_req);

    // R2: abort comes with a late-collision close
    p_abort_close_r2: assert property (@(posedge clk) disable iff (rst)
        abort_req |-> (close_vld && close_late_col && !close_hb_err));

    // R3: an ordinary collision never aborts
    p_norm_no_abort_r3: assert property (@(posedge clk) disable iff (rst)
        norm_col |-> !abort_req);

    // R4: abort halts the channel
    p_abort_halts_r4: assert property (@(posedge clk) disable iff (rst)
        abort_req |-> !tx_permit);

    // R4: a halted channel stays silent until restarted
    p_halt_silent_r4: assert property (@(posedge clk) disable iff (rst)
        (!tx_permit && !restart_cmd) |=> (!tx_permit && !abort_req && !norm_col && !close_vld));

    // R4: restart resumes the channel
    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        (!tx_permit && restart_cmd) |=> tx_permit);

    // R6: a fault close always leaves the event set
    p_fault_event_r6: assert property (@(posedge clk) disable iff (rst)
        (close_hb_err || close_late_col) |-> evt_flag);

    // R8: event is sticky without a clear
    p_evt_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (evt_flag && !evt_clr) |=> evt_flag);

    // R10: status bits only with the close strobe, never both
    p_flags_gated_r10: assert property (@(posedge clk) disable iff (rst)
        !close_vld |-> (!close_late_col && !close_hb_err));

    p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
        close_vld |-> !(close_late_col && close_hb_err));
endmodule

bind txmon_top txmon_checker u_chk (.*);

// File: tb/txmon_top_test.sv
module txmon_top_test;
    localparam int LB = 64;
    localparam int HW = 20;

    logic clk = 1'b0;
    logic rst, tx_active, tx_byte, tx_end, col_in, hb_check_en, irq_en, restart_cmd, evt_clr;
    logic tx_permit, abort_req, norm_col, close_vld, close_late_col, close_hb_err, evt_flag, irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    txmon_top #(.LATE_BYTES(LB), .HB_WINDOW(HW)) uut (
        .clk(clk), .rst(rst), .tx_active(tx_active), .tx_byte(tx_byte), .tx_end(tx_end),
        .col_in(col_in), .hb_check_en(hb_check_en), .irq_en(irq_en),
        .restart_cmd(restart_cmd), .evt_clr(evt_clr), .tx_permit(tx_permit),
        .abort_req(abort_req), .norm_col(norm_col), .close_vld(close_vld),
        .close_late_col(close_late_col), .close_hb_err(close_hb_err),
        .evt_flag(evt_flag), .irq(irq)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_evt();
        evt_clr = 1'b1;
        step();
        evt_clr = 1'b0;
        chk("R8 cleared", int'(evt_flag), 0);
        chk("R9 irq low after clear", int'(irq), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; tx_active = 0; tx_byte = 0; tx_end = 0; col_in = 0;
        hb_check_en = 0; irq_en = 1; restart_cmd = 0; evt_clr = 0;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1 tx_permit", int'(tx_permit), 1);
        chk("R1 abort", int'(abort_req), 0);
        chk("R1 norm", int'(norm_col), 0);
        chk("R1 close", int'(close_vld), 0);
        chk("R1 flags", int'({close_late_col, close_hb_err}), 0);
        chk("R1 evt", int'(evt_flag), 0);
        chk("R1 irq", int'(irq), 0);

        // Collision position sweep: late iff byte count >= LB
        for (int n = 0; n <= LB + 2; n++) begin
            bit late;
            late = (n >= LB);
            tx_active = 1'b1;
            for (int i = 0; i < n; i++) begin
                tx_byte = 1'b1;
                step();
            end
            tx_byte = 1'b0;
            col_in = 1'b1;
            step();
            col_in = 1'b0;
            chk($sformatf("R2 abort n=%0d", n), int'(abort_req), int'(late));
            chk($sformatf("R2 close n=%0d", n), int'(close_vld), int'(late));
            chk($sformatf("R2 late bit n=%0d", n), int'(close_late_col), int'(late));
            chk($sformatf("R10 hb bit n=%0d", n), int'(close_hb_err), 0);
            chk($sformatf("R3 norm n=%0d", n), int'(norm_col), int'(!late));
            chk($sformatf("R4 permit n=%0d", n), int'(tx_permit), int'(!late));
            chk($sformatf("R9 irq n=%0d", n), int'(irq), int'(late));
            step();
            chk("R2 abort one cycle", int'(abort_req), 0);
            chk("R10 close one cycle", int'(close_vld), 0);
            if (late) begin
                // Halted: collisions and frame end ignored
                col_in = 1'b1;
                step();
                col_in = 1'b0;
                chk("R4 halted col", int'(abort_req | norm_col | close_vld), 0);
                tx_end = 1'b1;
                step();
                tx_end = 1'b0;
                step();
                chk("R4 halted end", int'(close_vld), 0);
                chk("R4 still halted", int'(tx_permit), 0);
                tx_active = 1'b0;
                restart_cmd = 1'b1;
                step();
                restart_cmd = 1'b0;
                chk("R4 restart", int'(tx_permit), 1);
                chk("R8 sticky through halt", int'(evt_flag), 1);
                clear_evt();
            end else begin
                chk("R3 no event", int'(evt_flag), 0);
                tx_active = 1'b0;
                step();
            end
        end

        // Heartbeat offset sweep
        hb_check_en = 1'b1;
        for (int e = 0; e < 2; e++) begin
            irq_en = e[0];
            for (int j = 1; j <= HW + 2; j++) begin
                bit miss;
                miss = (j > HW);
                tx_end = 1'b1;
                step();
                tx_end = 1'b0;
                chk("R5 no immediate close", int'(close_vld), 0);
                for (int t = 1; t <= HW; t++) begin
                    bit exp_close;
                    exp_close = (t == j) || (miss && t == HW);
                    col_in = (t == j);
                    step();
                    col_in = 1'b0;
                    chk($sformatf("R5 close j=%0d t=%0d", j, t), int'(close_vld), int'(exp_close));
                    chk($sformatf("R6 hb bit j=%0d t=%0d", j, t), int'(close_hb_err), int'(exp_close && miss));
                    chk($sformatf("R10 late bit j=%0d t=%0d", j, t), int'(close_late_col), 0);
                end
                if (j == HW + 1) begin
                    col_in = 1'b1;
                    step();
                    col_in = 1'b0;
                    chk("R6 late heartbeat ignored", int'(close_vld | norm_col), 0);
                end
                step();
                chk($sformatf("R6 evt j=%0d", j), int'(evt_flag), int'(miss));
                chk($sformatf("R9 irq j=%0d en=%0d", j, e), int'(irq), int'(miss && e == 1));
                if (miss) clear_evt();
            end
        end

        // Set wins over a simultaneous clear
        irq_en = 1'b1;
        tx_end = 1'b1;
        step();
        tx_end = 1'b0;
        repeat (HW - 1) step();
        evt_clr = 1'b1;
        step();
        evt_clr = 1'b0;
        chk("R8 set beats clear close", int'(close_hb_err), 1);
        chk("R8 set beats clear", int'(evt_flag), 1);
        clear_evt();

        // Heartbeat checking off: immediate clean close, no window
        hb_check_en = 1'b0;
        tx_end = 1'b1;
        step();
        tx_end = 1'b0;
        chk("R7 close", int'(close_vld), 1);
        chk("R7 flags", int'({close_late_col, close_hb_err}), 0);
        for (int t = 0; t < HW + 5; t++) begin
            step();
            chk("R7 no later close", int'(close_vld), 0);
        end
        chk("R7 no event", int'(evt_flag), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule